// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises host software by measuring the time since the last software kick. When a first, selectable deadline passes without a kick, it raises a sticky warning interrupt. When a second deadline, selected on its own, passes, it emits a one-cycle board reset request. Software talks to it over a simple 8-bit write/read register port with three registers: a trigger register (kick, interrupt clear and status), a timeout control register (two 4-bit timeout codes) and an interrupt enable register.

The watchdog sleeps after reset and arms itself on the first kick. From then on no software write can stop it; only the block's own reset makes it dormant again. A board strap input must be high for the watchdog to arm or to raise any event. A prescaler divides the system clock down to a 1 ms tick, and the timeout counter advances on that tick. Each deadline is chosen from a fixed 15-step table running from 125 ms to one hour, in steps that grow by a factor between 1.5 and 3.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, `irq_o` and `board_rst_o` are 0, the watchdog is dormant (trigger register read bit 0 is 0), the control register reads 0x45 (reset code 5 = 2.5 s, warning code 4 = 1 s) and the enable register reads 0x00.
- R2: While dormant (no kick accepted since reset), `board_rst_o` and `irq_o` stay 0 for any timeout setting.
- R3: With `strap_en_i` low, a kick is ignored (the watchdog stays dormant, read bit 0 stays 0) and neither `irq_o` nor `board_rst_o` rises.
- R4: One tick is CLK_HZ/1000 clock cycles. Writing a 1 to bit 0 of register 0 (address 0) is a kick. The reset deadline code sits in control register (address 1) bits [3:0], the warning code in bits [7:4]. `board_rst_o` is high for exactly one cycle, first in the cycle that follows the clock edge lying T x CLK_HZ/1000 edges after the edge that accepted the kick, T being the reset deadline in ms.
- R5: Codes map to deadlines 1:125 ms, 2:250 ms, 3:500 ms, 4:1 s, 5:2.5 s, 6:5 s, 7:10 s, 8:20 s, 9:30 s, 10:1 min, 11:2 min, 12:5 min, 13:10 min, 14:30 min, 15:60 min; code 0 acts as code 1.
- R6: Every kick while running restarts the measurement from zero; a kick accepted on the same edge at which the reset deadline would expire suppresses that reset pulse.
- R7: Once running, the watchdog cannot be stopped by writes to any register; without kicks `board_rst_o` pulses again every reset deadline after the previous pulse.
- R8: If enable register (address 2) bit 0 is 1, `irq_o` rises W x CLK_HZ/1000 edges after the kick edge, W being the warning deadline; it stays high until a write with bit 7 of register 0 set clears it. Register 0 read bit 7 mirrors the interrupt status. With the enable bit 0 the interrupt never rises.
- R9: If the warning deadline is equal to or longer than the reset deadline, no interrupt is raised; only the reset pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low block reset |
| strap_en_i | input | 1 | Board strap allowing the watchdog to operate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Sticky warning interrupt |
| board_rst_o | output | 1 | One-cycle board reset request |

## Verification
The functions that can meet in one cycle are a software kick and the expiry of the reset deadline. The bench provokes this by timing a kick write so that it is accepted on exactly the clock edge where the deadline tick lands, then judges that no reset pulse appears after that edge and that the next pulse comes one full deadline later, counted from the late kick. A second such meeting, a warning expiry next to an interrupt clear, is covered by the rule that setting wins and is checked by clearing only after the interrupt has been seen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 22;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    typedef logic [CNT_W-1:0]  ticks_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam logic [ADDR_W-1:0] A_TRIG = 2'd0;
    localparam logic [ADDR_W-1:0] A_TCTL = 2'd1;
    localparam logic [ADDR_W-1:0] A_IEN  = 2'd2;

    localparam logic [REG_W-1:0] TCTL_RESET = 8'h45;

    function automatic ticks_t code_to_ticks(input code_t code);
        ticks_t t;
        case (code)
            4'd0, 4'd1: t = ticks_t'(125);
            4'd2:  t = ticks_t'(250);
            4'd3:  t = ticks_t'(500);
            4'd4:  t = ticks_t'(1000);
            4'd5:  t = ticks_t'(2500);
            4'd6:  t = ticks_t'(5000);
            4'd7:  t = ticks_t'(10000);
            4'd8:  t = ticks_t'(20000);
            4'd9:  t = ticks_t'(30000);
            4'd10: t = ticks_t'(60000);
            4'd11: t = ticks_t'(120000);
            4'd12: t = ticks_t'(300000);
            4'd13: t = ticks_t'(600000);
            4'd14: t = ticks_t'(1800000);
            default: t = ticks_t'(3600000);
        endcase
        return t;
    endfunction

    typedef struct packed {
        logic   run;
        ticks_t cnt;
        logic   pulse;
    } cnt_state_t;

    typedef struct packed {
        logic [REG_W-1:0] tctl;
        logic             ien;
        logic             stat;
    } reg_state_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clear_i) begin
            pre_d = '0;
        end else if (pre_q == LAST) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_o = !clear_i && (pre_q == LAST);

    a_r4_pre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);
endmodule

// File: rtl/wdt_timeout_sel.sv
module wdt_timeout_sel
    import wdt_pkg::*;
#(
    parameter int N_SEL = 2
) (
    input  logic [N_SEL*CODE_W-1:0] codes_i,
    output logic [N_SEL*CNT_W-1:0]  ticks_o
);
    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        assign ticks_o[g*CNT_W +: CNT_W] = code_to_ticks(codes_i[g*CODE_W +: CODE_W]);
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              run_i,
    input  logic              warn_hit_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              kick_o,
    output code_t             rst_code_o,
    output code_t             warn_code_o,
    output logic              stat_o
);
    reg_state_t s_d, s_q;
    logic       clr_req;

    assign kick_o  = wr_en_i && (wr_addr_i == A_TRIG) && wr_data_i[0];
    assign clr_req = wr_en_i && (wr_addr_i == A_TRIG) && wr_data_i[7];

    always_comb begin
        s_d = s_q;
        if (wr_en_i && wr_addr_i == A_TCTL) s_d.tctl = wr_data_i;
        if (wr_en_i && wr_addr_i == A_IEN)  s_d.ien  = wr_data_i[0];
        if (warn_hit_i && s_q.ien) begin
            s_d.stat = 1'b1;
        end else if (clr_req) begin
            s_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tctl <= TCTL_RESET;
            s_q.ien  <= 1'b0;
            s_q.stat <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_TRIG:  rd_data_o = {s_q.stat, 6'b0, run_i};
            A_TCTL:  rd_data_o = s_q.tctl;
            A_IEN:   rd_data_o = {7'b0, s_q.ien};
            default: rd_data_o = '0;
        endcase
    end

    assign rst_code_o  = s_q.tctl[3:0];
    assign warn_code_o = s_q.tctl[7:4];
    assign stat_o      = s_q.stat;

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.stat) |-> $past(s_q.ien));
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stat && !clr_req) |=> s_q.stat);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   strap_i,
    input  logic   kick_i,
    input  logic   tick_i,
    input  ticks_t warn_ticks_i,
    input  ticks_t rst_ticks_i,
    output logic   run_o,
    output logic   warn_hit_o,
    output logic   pulse_o
);
    cnt_state_t s_d, s_q;
    logic       kick_ok;
    logic       warn_valid;

    assign kick_ok    = kick_i && strap_i;
    assign warn_valid = warn_ticks_i < rst_ticks_i;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (!s_q.run) begin
            s_d.cnt = '0;
            if (kick_ok) s_d.run = 1'b1;
        end else if (kick_ok || !strap_i) begin
            s_d.cnt = '0;
        end else if (tick_i) begin
            if (s_q.cnt >= rst_ticks_i - 1'b1) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    assign warn_hit_o = s_q.run && strap_i && !kick_ok && tick_i && warn_valid
                        && (s_q.cnt == warn_ticks_i - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run   <= 1'b0;
            s_q.cnt   <= '0;
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o   = s_q.run;
    assign pulse_o = s_q.pulse;

    a_r7_never_stops: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |=> s_q.run);
    a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |=> !s_q.pulse);
    a_r2_dormant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |=> !s_q.pulse);
    a_r6_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_ok && s_q.run) |=> (!s_q.pulse && s_q.cnt == '0));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdt_pkg::*;
#(
    parameter int CLK_HZ = 100000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o,
    output logic              board_rst_o
);
    localparam int TICK_HZ = 1000;
    localparam int DIV     = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

    logic   kick, run, tick, warn_hit, pre_clear;
    code_t  rst_code, warn_code;
    ticks_t rst_ticks, warn_ticks;
    logic [2*CNT_W-1:0] sel_ticks;

    wdt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_addr_i   (rd_addr_i),
        .run_i       (run),
        .warn_hit_i  (warn_hit),
        .rd_data_o   (rd_data_o),
        .kick_o      (kick),
        .rst_code_o  (rst_code),
        .warn_code_o (warn_code),
        .stat_o      (irq_o)
    );

    wdt_timeout_sel #(.N_SEL(2)) u_sel (
        .codes_i ({warn_code, rst_code}),
        .ticks_o (sel_ticks)
    );

    assign rst_ticks  = sel_ticks[0 +: CNT_W];
    assign warn_ticks = sel_ticks[CNT_W +: CNT_W];

    assign pre_clear = !run || !strap_en_i || (kick && strap_en_i);

    wdt_prescaler #(.DIV(DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pre_clear),
        .tick_o  (tick)
    );

    wdt_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_i      (strap_en_i),
        .kick_i       (kick),
        .tick_i       (tick),
        .warn_ticks_i (warn_ticks),
        .rst_ticks_i  (rst_ticks),
        .run_o        (run),
        .warn_hit_o   (warn_hit),
        .pulse_o      (board_rst_o)
    );

    a_r3_strap_gates_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_en_i |=> !board_rst_o);
    a_r3_strap_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_en_i |=> !$rose(irq_o));
    a_r9_no_late_warning: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_ticks >= rst_ticks) |-> !warn_hit);
endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
    localparam int CLK_HZ = 4000;
    localparam int DIV    = CLK_HZ / 1000;
    localparam int NV     = 6;

    localparam int V_WARN [NV] = '{1, 2, 3, 0, 4, 1};
    localparam int V_RST  [NV] = '{2, 3, 3, 0, 2, 4};
    localparam int V_IEN  [NV] = '{1, 0, 1, 1, 1, 1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq, brst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_two_stage #(.CLK_HZ(CLK_HZ)) u_wdog_two_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_en_i  (strap),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .irq_o       (irq),
        .board_rst_o (brst)
    );

    function automatic int ms_of(input int code);
        case (code)
            0, 1: return 125;
            2: return 250;
            3: return 500;
            4: return 1000;
            5: return 2500;
            6: return 5000;
            7: return 10000;
            default: return 20000;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the accepting edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic board_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_for(input int n, output int pulses, output int first_rst,
                           output int first_irq, output int wide);
        pulses = 0; first_rst = 0; first_irq = 0; wide = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (irq && first_irq == 0) first_irq = i;
            if (brst) begin
                if (first_rst == 0) first_rst = i;
                if (i == first_rst + 1) wide = 1;
                pulses++;
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int v, p, fr, fi, wd;
        board_reset();

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 board_rst", int'(brst), 0);
        rd(2'd0, v); chk("R1 trig read", v, 0);
        rd(2'd1, v); chk("R1 tctl read", v, 8'h45);
        rd(2'd2, v); chk("R1 ien read", v, 0);

        // R2 dormant: no kick, short deadlines
        wr(2'd1, 8'h11); wr(2'd2, 8'h01);
        run_for(1500, p, fr, fi, wd);
        chk("R2 no pulse while dormant", p, 0);
        chk("R2 no irq while dormant", fi, 0);

        // R3 strap low ignores kick
        strap = 1'b0;
        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R3 still dormant", v & 1, 0);
        run_for(1500, p, fr, fi, wd);
        chk("R3 no pulse strap low", p, 0);
        chk("R3 no irq strap low", fi, 0);
        strap = 1'b1;
        run_for(600, p, fr, fi, wd);
        chk("R3 kick not remembered", p, 0);

        // vector table: R4 R5 R8 R9
        for (int k = 0; k < NV; k++) begin
            int exp_irq, exp_rst;
            board_reset();
            wr(2'd1, 8'((V_WARN[k] << 4) | V_RST[k]));
            wr(2'd2, 8'(V_IEN[k]));
            wr(2'd0, 8'h01);
            exp_rst = ms_of(V_RST[k]) * DIV;
            exp_irq = (V_IEN[k] != 0 && ms_of(V_WARN[k]) < ms_of(V_RST[k]))
                      ? ms_of(V_WARN[k]) * DIV : 0;
            run_for(exp_rst + 2, p, fr, fi, wd);
            chk($sformatf("R4 R5 vec%0d reset cycle", k), fr, exp_rst);
            chk($sformatf("R4 vec%0d pulse width", k), wd, 0);
            chk($sformatf("R8 R9 vec%0d irq cycle", k), fi, exp_irq);
        end

        // R5 R1 default reset deadline 2.5 s
        board_reset();
        wr(2'd0, 8'h01);
        run_for(2500 * DIV + 2, p, fr, fi, wd);
        chk("R5 default 2.5 s reset", fr, 2500 * DIV);

        // R7 cannot stop, pulses repeat
        board_reset();
        wr(2'd1, 8'h11);
        wr(2'd0, 8'h01);
        run_for(1002, p, fr, fi, wd);
        chk("R7 first pulse", fr, 500);
        chk("R7 repeat pulses", p, 2);
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h11);
        rd(2'd0, v); chk("R7 still running", v & 1, 1);
        run_for(1000, p, fr, fi, wd);
        chk("R7 pulses after stop attempts", p, 2);

        // R6 keepalive kicks
        board_reset();
        wr(2'd1, 8'h11);
        wr(2'd0, 8'h01);
        v = 0;
        for (int j = 0; j < 5; j++) begin
            run_for(400, p, fr, fi, wd);
            v += p;
            wr(2'd0, 8'h01);
        end
        chk("R6 no pulse with kicks", v, 0);
        run_for(502, p, fr, fi, wd);
        chk("R6 pulse after last kick", fr, 500);

        // R6 kick on the expiring edge
        board_reset();
        wr(2'd1, 8'h11);
        wr(2'd0, 8'h01);
        run_for(499, p, fr, fi, wd);
        chk("R6 quiet before expiry", p, 0);
        wr(2'd0, 8'h01);
        chk("R6 coincident kick suppresses pulse", int'(brst), 0);
        run_for(502, p, fr, fi, wd);
        chk("R6 restart from coincident kick", fr, 500);

        // R8 sticky irq and clear
        board_reset();
        wr(2'd1, 8'h12);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h01);
        run_for(700, p, fr, fi, wd);
        chk("R8 irq rises", fi, 500);
        chk("R8 irq held", int'(irq), 1);
        rd(2'd0, v); chk("R8 status bit7", (v >> 7) & 1, 1);
        wr(2'd0, 8'h80);
        chk("R8 irq cleared", int'(irq), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule